// File: doc/BRIEF.md
# Multi-Mode Up/Down Position Counter

This block tracks encoder position. An upstream decoder supplies a count strobe with a direction bit and a separate index strobe. The block keeps a position counter, a preset/compare register, a snapshot register, two mode registers and a status word. The counter can run in one of four count modes: free-running, single-cycle, range-limit or modulo-N. Its active width can be set to 1, 2, 3 or 4 bytes. That width rescales wrap, carry, borrow and the sign bit, and it also applies to the preset and snapshot registers.

Software, or a serial front end, reaches the registers through a one-cycle command port. Each command is an operation code plus a register selector. Reads are combinational on `rd_data_o` for whichever register `cmd_sel_i` names.

Two flag outputs report carry, borrow, compare and index events. Each event has its own enable bit. One flag output is sticky until the status word is cleared. The other pulses low for exactly one clock.

Top module: `pos_counter`

## Requirements
- R1: After reset the counter, preset, snapshot and both mode registers read 0. The status word reads 0x04: power-loss bit set, and count-enable bit 0 while `cnt_en_i` is low. Both flag outputs are high.
- R2: In free-running mode (mode0 bits 3:2 = 00), an up step from the all-ones value of the active width gives 0 and sets the carry latch (status bit 7). Mode1 bits 1:0 select the width: 00 gives 4 bytes, 01 gives 3, 10 gives 2 and 11 gives 1.
- R3: A down step from 0 gives the all-ones value of the active width and sets the borrow latch (status bit 6). Status bit 0 equals the top bit of the active width. Status bit 1 holds the direction of the last accepted step (1 = up).
- R4: A count strobe is accepted only when `cnt_en_i` is 1 and mode1 bit 2 is 0. Status bit 3 shows (`cnt_en_i` and not mode1 bit 2).
- R5: Single-cycle mode (01) wraps on carry or borrow and then freezes the counter. Only a counter clear or a counter load restarts it.
- R6: Range-limit mode (10) handles the two limits as follows. An up step at the preset value holds the count and signals carry. A down step at 0 holds the count and signals borrow. All other steps move by one.
- R7: Modulo-N mode (11) wraps at the preset value. Up from the preset value gives 0 with carry. Down from 0 gives the preset value with borrow.
- R8: An index strobe always sets the index latch (status bit 4). Mode0 bits 5:4 then choose its action: 00 has no action, 01 loads the counter from the preset register, 10 clears the counter, and 11 copies the counter into the snapshot register.
- R9: An accepted step whose new count equals the preset value sets the compare latch (status bit 5).
- R10: Status clear (op 2, select 4) zeroes the four event latches, the power-loss bit and the direction bit. It also releases the sticky flag. If an event arrives in the same cycle, the event wins.
- R11: Mode1 bits 7, 6, 5 and 4 enable carry, borrow, compare and index respectively for both flags. An enabled event drives `lflag_no` low until status clear and drives `dflag_no` low for exactly one clock. Disabled events still set their status latches.
- R12: Commands are coded as follows. Op codes are 0 write, 1 read, 2 clear and 3 transfer. Select codes are 1 counter, 2 preset, 3 snapshot, 4 status, 5 mode0 and 6 mode1. Write stores into preset, mode0 or mode1. Read of the counter also copies it to the snapshot register. Clear zeroes the counter, mode0 or mode1. Transfer on the counter loads it from preset, and transfer on the snapshot copies the counter into it. Writes to the status word are ignored. Mode0 bits 7:6 and 1:0 and mode1 bit 3 read 0.
- R13: A counter clear or load command beats a count strobe in the same cycle, and the strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_pulse_i | input | 1 | Count strobe from the decoder |
| cnt_up_i | input | 1 | Direction of the strobe, 1 = up |
| cnt_en_i | input | 1 | External count enable |
| idx_i | input | 1 | Index strobe |
| cmd_valid_i | input | 1 | Command valid for one cycle |
| cmd_op_i | input | 2 | Operation code |
| cmd_sel_i | input | 3 | Register selector, also selects read data |
| cmd_wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Selected register, masked to active width |
| lflag_no | output | 1 | Sticky event flag, active low |
| dflag_no | output | 1 | One-clock event flag, active low |

## Verification
The bench targets the width boundaries in every byte size. A design with the wrong mask would wrap at the wrong value or miss carry and borrow entirely.

It drives the range-limit and modulo-N limits in both directions. An off-by-one there would either move past the preset value or return to it through the wrong endpoint.

It also continues stepping past a single-cycle wrap. A counter that does not freeze there keeps moving and fails the check.

A strobe arriving together with a counter load shows whether the command really takes precedence. Masked events that still light the sticky flag, and a pulsed flag that lasts longer than one clock, are both visible at the flag outputs.

// File: rtl/pos_counter_pkg.sv
package pos_counter_pkg;
  localparam int unsigned CNT_W = 32;
  localparam int unsigned REG_W = 8;
  localparam int unsigned EV_N  = 4;

  typedef enum logic [1:0] {OP_WRITE, OP_READ, OP_CLEAR, OP_XFER} op_e;
  typedef enum logic [2:0] {
    SEL_NONE, SEL_COUNT, SEL_DATA, SEL_SNAP,
    SEL_STATUS, SEL_MODE0, SEL_MODE1, SEL_SPARE
  } sel_e;
  typedef enum logic [1:0] {CM_FREE, CM_SINGLE, CM_RANGE, CM_MODN} cmode_e;
  typedef enum logic [1:0] {IX_NONE, IX_LOAD, IX_CLEAR, IX_SNAP} ixact_e;

  // width code 0 keeps all bytes, each step drops one byte
  function automatic logic [CNT_W-1:0] width_mask(input logic [1:0] code);
    return {CNT_W{1'b1}} >> (8 * int'(code));
  endfunction
endpackage

// File: rtl/pos_counter_core.sv
module pos_counter_core
  import pos_counter_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  cmode_e       mode_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] data_i,
  input  logic         step_i,
  input  logic         up_i,
  input  logic         clr_i,
  input  logic         load_i,
  output logic [W-1:0] cnt_o,
  output logic         halt_o,
  output logic         ev_cy_o,
  output logic         ev_bw_o,
  output logic         ev_cmp_o
);
  logic [W-1:0] cnt_q, cnt_m, nxt;
  logic         halt_q, cy, bw, bounded;

  assign cnt_m   = cnt_q & mask_i;
  assign bounded = (mode_i == CM_RANGE) || (mode_i == CM_MODN);

  always_comb begin
    nxt = cnt_m;
    cy  = 1'b0;
    bw  = 1'b0;
    if (up_i) begin
      if (bounded && cnt_m == data_i) begin
        nxt = (mode_i == CM_RANGE) ? cnt_m : '0;
        cy  = 1'b1;
      end else begin
        nxt = (cnt_m + 1'b1) & mask_i;
        cy  = (cnt_m == mask_i);
      end
    end else begin
      if (bounded && cnt_m == '0) begin
        nxt = (mode_i == CM_RANGE) ? cnt_m : data_i;
        bw  = 1'b1;
      end else begin
        nxt = (cnt_m - 1'b1) & mask_i;
        bw  = (cnt_m == '0);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      halt_q <= 1'b0;
    end else begin
      if (clr_i)       cnt_q <= '0;
      else if (load_i) cnt_q <= data_i;
      else if (step_i) cnt_q <= nxt;

      if (clr_i || load_i) halt_q <= 1'b0;
      else if (step_i && mode_i == CM_SINGLE && (cy || bw)) halt_q <= 1'b1;
    end
  end

  assign cnt_o    = cnt_m;
  assign halt_o   = halt_q;
  assign ev_cy_o  = step_i & cy;
  assign ev_bw_o  = step_i & bw;
  assign ev_cmp_o = step_i & (nxt == data_i);
endmodule

// File: rtl/pos_counter_status.sv
module pos_counter_status
  import pos_counter_pkg::*;
#(
  parameter int unsigned N = EV_N,
  parameter int unsigned SW = REG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  ev_i,     // {cy, bw, cmp, idx}
  input  logic [N-1:0]  en_i,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic          up_i,
  input  logic          cen_i,
  input  logic          sign_i,
  output logic [SW-1:0] status_o,
  output logic          lflag_no,
  output logic          dflag_no
);
  logic [N-1:0] lat_q;
  logic         pls_q, dir_q, lflag_q, dflag_q, hit;

  assign hit = |(ev_i & en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q   <= '0;
      pls_q   <= 1'b1;
      dir_q   <= 1'b0;
      lflag_q <= 1'b0;
      dflag_q <= 1'b0;
    end else begin
      lat_q   <= (clr_i ? '0 : lat_q) | ev_i;
      lflag_q <= (clr_i ? 1'b0 : lflag_q) | hit;
      dflag_q <= hit;
      if (clr_i) pls_q <= 1'b0;
      if (step_i)     dir_q <= up_i;
      else if (clr_i) dir_q <= 1'b0;
    end
  end

  assign status_o = {lat_q, cen_i, pls_q, dir_q, sign_i};
  assign lflag_no = ~lflag_q;
  assign dflag_no = ~dflag_q;
endmodule

// File: rtl/pos_counter.sv
module pos_counter
  import pos_counter_pkg::*;
#(
  parameter int unsigned W = CNT_W,
  parameter int unsigned RW = REG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cnt_pulse_i,
  input  logic         cnt_up_i,
  input  logic         cnt_en_i,
  input  logic         idx_i,
  input  logic         cmd_valid_i,
  input  logic [1:0]   cmd_op_i,
  input  logic [2:0]   cmd_sel_i,
  input  logic [W-1:0] cmd_wdata_i,
  output logic [W-1:0] rd_data_o,
  output logic         lflag_no,
  output logic         dflag_no
);
  logic [3:0]    m0_q;       // {index action, count mode}
  logic [3:0]    m1_en_q;    // flag enables {cy, bw, cmp, idx}
  logic          m1_dis_q;
  logic [1:0]    m1_wid_q;
  logic [W-1:0]  data_q, snap_q, mask, data_m, cnt_m;
  logic [RW-1:0] status, mode0_rd, mode1_rd;
  logic          halt, step, cen, sign, ev_cy, ev_bw, ev_cmp;
  logic          c_wr, c_rd, c_clr, c_xf, cnt_clr_c, cnt_ld_c, cnt_cmd;
  logic          ix_ld, ix_clr, ix_snap, st_clr;
  op_e           op;
  sel_e          sel;
  cmode_e        cmode;
  ixact_e        ixact;

  assign op     = op_e'(cmd_op_i);
  assign sel    = sel_e'(cmd_sel_i);
  assign cmode  = cmode_e'(m0_q[1:0]);
  assign ixact  = ixact_e'(m0_q[3:2]);
  assign mask   = width_mask(m1_wid_q);
  assign data_m = data_q & mask;

  assign c_wr  = cmd_valid_i && op == OP_WRITE;
  assign c_rd  = cmd_valid_i && op == OP_READ;
  assign c_clr = cmd_valid_i && op == OP_CLEAR;
  assign c_xf  = cmd_valid_i && op == OP_XFER;

  assign cnt_clr_c = c_clr && sel == SEL_COUNT;
  assign cnt_ld_c  = c_xf && sel == SEL_COUNT;
  assign cnt_cmd   = cnt_clr_c || cnt_ld_c;
  assign st_clr    = c_clr && sel == SEL_STATUS;

  // command > index > count strobe on the counter
  assign ix_ld   = idx_i && ixact == IX_LOAD && !cnt_cmd;
  assign ix_clr  = idx_i && ixact == IX_CLEAR && !cnt_cmd;
  assign ix_snap = idx_i && ixact == IX_SNAP;

  assign cen  = cnt_en_i && !m1_dis_q;
  assign step = cnt_pulse_i && cen && !halt && !cnt_cmd && !ix_ld && !ix_clr;
  assign sign = |(cnt_m & ~(mask >> 1));

  pos_counter_core #(.W(W)) i_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (cmode),
    .mask_i  (mask),
    .data_i  (data_m),
    .step_i  (step),
    .up_i    (cnt_up_i),
    .clr_i   (cnt_clr_c || ix_clr),
    .load_i  (cnt_ld_c || ix_ld),
    .cnt_o   (cnt_m),
    .halt_o  (halt),
    .ev_cy_o (ev_cy),
    .ev_bw_o (ev_bw),
    .ev_cmp_o(ev_cmp)
  );

  pos_counter_status #(.N(EV_N), .SW(RW)) i_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ev_i    ({ev_cy, ev_bw, ev_cmp, idx_i}),
    .en_i    (m1_en_q),
    .clr_i   (st_clr),
    .step_i  (step),
    .up_i    (cnt_up_i),
    .cen_i   (cen),
    .sign_i  (sign),
    .status_o(status),
    .lflag_no(lflag_no),
    .dflag_no(dflag_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m0_q     <= '0;
      m1_en_q  <= '0;
      m1_dis_q <= 1'b0;
      m1_wid_q <= '0;
      data_q   <= '0;
      snap_q   <= '0;
    end else begin
      if (c_wr && sel == SEL_MODE0)       m0_q <= cmd_wdata_i[5:2];
      else if (c_clr && sel == SEL_MODE0) m0_q <= '0;

      if (c_wr && sel == SEL_MODE1) begin
        m1_en_q  <= cmd_wdata_i[7:4];
        m1_dis_q <= cmd_wdata_i[2];
        m1_wid_q <= cmd_wdata_i[1:0];
      end else if (c_clr && sel == SEL_MODE1) begin
        m1_en_q  <= '0;
        m1_dis_q <= 1'b0;
        m1_wid_q <= '0;
      end

      if (c_wr && sel == SEL_DATA) data_q <= cmd_wdata_i & mask;

      if ((c_rd && sel == SEL_COUNT) || (c_xf && sel == SEL_SNAP) || ix_snap)
        snap_q <= cnt_m;
    end
  end

  assign mode0_rd = {2'b00, m0_q, 2'b00};
  assign mode1_rd = {m1_en_q, 1'b0, m1_dis_q, m1_wid_q};

  always_comb begin
    unique case (sel)
      SEL_COUNT:  rd_data_o = cnt_m;
      SEL_DATA:   rd_data_o = data_m;
      SEL_SNAP:   rd_data_o = snap_q & mask;
      SEL_STATUS: rd_data_o = W'(status);
      SEL_MODE0:  rd_data_o = W'(mode0_rd);
      SEL_MODE1:  rd_data_o = W'(mode1_rd);
      default:    rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/pos_counter_checker.sv
module pos_counter_checker
  import pos_counter_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         cnt_en_i,
  input logic         idx_i,
  input logic         cmd_valid_i,
  input logic [1:0]   cmd_op_i,
  input logic [2:0]   cmd_sel_i,
  input logic [W-1:0] cnt_i,
  input logic         halt_i,
  input logic [7:0]   status_i,
  input logic         lflag_ni,
  input logic         dflag_ni
);
  logic st_clr, cnt_clr;
  assign st_clr  = cmd_valid_i && cmd_op_i == OP_CLEAR && cmd_sel_i == SEL_STATUS;
  assign cnt_clr = cmd_valid_i && cmd_op_i == OP_CLEAR && cmd_sel_i == SEL_COUNT;

  AST_CNT_HOLD_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_i && !cmd_valid_i && !idx_i |=> $stable(cnt_i)); // R4
  AST_HALT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i && !cmd_valid_i && !idx_i |=> $stable(cnt_i)); // R5
  AST_PLS_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[2] && !st_clr |=> status_i[2]); // R10
  AST_LFLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lflag_ni && !st_clr |=> !lflag_ni); // R11
  AST_DFLAG_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dflag_ni |-> !lflag_ni); // R11
  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr |=> cnt_i == '0); // R12
endmodule

bind pos_counter pos_counter_checker #(.W(W)) i_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cnt_en_i   (cnt_en_i),
  .idx_i      (idx_i),
  .cmd_valid_i(cmd_valid_i),
  .cmd_op_i   (cmd_op_i),
  .cmd_sel_i  (cmd_sel_i),
  .cnt_i      (cnt_m),
  .halt_i     (halt),
  .status_i   (status),
  .lflag_ni   (lflag_no),
  .dflag_ni   (dflag_no)
);

// File: tb/test_pos_counter.sv
module test_pos_counter;
  import pos_counter_pkg::*;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        cnt_pulse_i = 0, cnt_up_i = 0, cnt_en_i = 0, idx_i = 0;
  logic        cmd_valid_i = 0;
  logic [1:0]  cmd_op_i = 0;
  logic [2:0]  cmd_sel_i = 0;
  logic [31:0] cmd_wdata_i = 0, rd_data_o;
  logic        lflag_no, dflag_no;
  int          checks = 0, errors = 0;
  logic [31:0] v, v2;

  always #5 clk_i = ~clk_i;

  pos_counter i_pos_counter (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic cmd(input logic [1:0] op, input logic [2:0] sel, input logic [31:0] wd);
    cmd_valid_i = 1; cmd_op_i = op; cmd_sel_i = sel; cmd_wdata_i = wd;
    tick();
    cmd_valid_i = 0;
  endtask

  task automatic pulse(input logic up);
    cnt_pulse_i = 1; cnt_up_i = up;
    tick();
    cnt_pulse_i = 0;
  endtask

  task automatic index();
    idx_i = 1; tick(); idx_i = 0;
  endtask

  task automatic peek(input logic [2:0] sel, output logic [31:0] val);
    cmd_sel_i = sel; #1; val = rd_data_o;
  endtask

  task automatic load_cnt(input logic [31:0] start, input logic [31:0] pre);
    cmd(OP_WRITE, SEL_DATA, start);
    cmd(OP_XFER, SEL_COUNT, 0);
    cmd(OP_WRITE, SEL_DATA, pre);
  endtask

  function automatic logic [31:0] wmask(input logic [1:0] w);
    return 32'hFFFF_FFFF >> (8 * int'(w));
  endfunction

  // {cy, bw, next} from the count-mode rules
  function automatic logic [33:0] ref_next(input logic [31:0] c, input logic up,
      input logic [1:0] m, input logic [31:0] d, input logic [31:0] mk);
    logic bnd = (m == 2'd2) || (m == 2'd3);
    if (up) begin
      if (bnd && c == d) return {2'b10, (m == 2'd2) ? c : 32'd0};
      return {c == mk, 1'b0, (c + 1) & mk};
    end
    if (bnd && c == 0) return {2'b01, (m == 2'd2) ? c : d};
    return {1'b0, c == 0, (c - 1) & mk};
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    tick();
    // R1 reset state
    peek(SEL_STATUS, v); chk("R1 status", v, 32'h04);
    peek(SEL_COUNT, v);  chk("R1 count", v, 0);
    peek(SEL_DATA, v);   chk("R1 preset", v, 0);
    peek(SEL_SNAP, v);   chk("R1 snap", v, 0);
    peek(SEL_MODE0, v);  chk("R1 mode0", v, 0);
    peek(SEL_MODE1, v);  chk("R1 mode1", v, 0);
    chk("R1 lflag", lflag_no, 1); chk("R1 dflag", dflag_no, 1);
    cnt_en_i = 1;

    // R2 1-byte carry, flag timing
    cmd(OP_WRITE, SEL_MODE1, 32'hF3);
    cmd(OP_WRITE, SEL_MODE0, 32'h00);
    load_cnt(32'hFF, 32'h10);
    cmd(OP_CLEAR, SEL_STATUS, 0);
    peek(SEL_STATUS, v); chk("R3 sign 1-byte", v[0], 1);
    pulse(1);
    peek(SEL_COUNT, v);  chk("R2 1-byte wrap", v, 0);
    peek(SEL_STATUS, v); chk("R2 carry latch", v[7], 1);
    chk("R11 lflag set", lflag_no, 0); chk("R11 dflag low", dflag_no, 0);
    tick();
    chk("R11 dflag one clock", dflag_no, 1); chk("R11 lflag held", lflag_no, 0);
    // R2 2-byte and 4-byte
    cmd(OP_WRITE, SEL_MODE1, 32'hF2);
    load_cnt(32'hFFFF, 32'h10); pulse(1);
    peek(SEL_COUNT, v); chk("R2 2-byte wrap", v, 0);
    cmd(OP_WRITE, SEL_MODE1, 32'hF0);
    load_cnt(32'hFFFF_FFFF, 32'h10); pulse(1);
    peek(SEL_COUNT, v); chk("R2 4-byte wrap", v, 0);
    // R3 3-byte borrow
    cmd(OP_WRITE, SEL_MODE1, 32'hF1);
    load_cnt(32'h0, 32'h10);
    cmd(OP_CLEAR, SEL_STATUS, 0);
    pulse(0);
    peek(SEL_COUNT, v);  chk("R3 3-byte underflow", v, 32'hFF_FFFF);
    peek(SEL_STATUS, v); chk("R3 borrow/sign/dir", {v[7:6], v[1:0]}, 4'b0101);
    pulse(1);
    peek(SEL_STATUS, v); chk("R3 dir up", v[1], 1);

    // R4 enables
    load_cnt(32'h20, 32'h10);
    cnt_en_i = 0; pulse(1);
    peek(SEL_COUNT, v);  chk("R4 en low no step", v, 32'h20);
    peek(SEL_STATUS, v); chk("R4 cen bit low", v[3], 0);
    cnt_en_i = 1;
    cmd(OP_WRITE, SEL_MODE1, 32'hF5); pulse(1);
    peek(SEL_COUNT, v);  chk("R4 disable bit no step", v, 32'h20);
    peek(SEL_STATUS, v); chk("R4 cen bit disabled", v[3], 0);
    cmd(OP_WRITE, SEL_MODE1, 32'hF1);
    peek(SEL_STATUS, v); chk("R4 cen bit high", v[3], 1);

    // R5 single-cycle
    cmd(OP_WRITE, SEL_MODE1, 32'hF3);
    cmd(OP_WRITE, SEL_MODE0, 32'h04);
    load_cnt(32'hFE, 32'h80);
    pulse(1); peek(SEL_COUNT, v); chk("R5 step to FF", v, 32'hFF);
    pulse(1); peek(SEL_COUNT, v); chk("R5 wrap", v, 0);
    pulse(1); pulse(0); peek(SEL_COUNT, v); chk("R5 frozen", v, 0);
    cmd(OP_XFER, SEL_COUNT, 0);
    peek(SEL_COUNT, v); chk("R5 load", v, 32'h80);
    pulse(1); peek(SEL_COUNT, v); chk("R5 resumed", v, 32'h81);

    // R6 range-limit
    cmd(OP_WRITE, SEL_MODE0, 32'h08);
    load_cnt(2, 3);
    cmd(OP_CLEAR, SEL_STATUS, 0);
    pulse(1); peek(SEL_COUNT, v); chk("R6 up to limit", v, 3);
    peek(SEL_STATUS, v); chk("R9 compare latch", v[7:5], 3'b001);
    pulse(1); peek(SEL_COUNT, v); chk("R6 hold at top", v, 3);
    peek(SEL_STATUS, v); chk("R6 carry at top", v[7], 1);
    pulse(0); peek(SEL_COUNT, v); chk("R6 reverse", v, 2);
    load_cnt(0, 3);
    cmd(OP_CLEAR, SEL_STATUS, 0);
    pulse(0); peek(SEL_COUNT, v); chk("R6 hold at zero", v, 0);
    peek(SEL_STATUS, v); chk("R6 borrow at zero", v[6], 1);
    pulse(1); peek(SEL_COUNT, v); chk("R6 leave zero", v, 1);

    // R7 modulo-N
    cmd(OP_WRITE, SEL_MODE0, 32'h0C);
    load_cnt(3, 3);
    cmd(OP_CLEAR, SEL_STATUS, 0);
    pulse(1); peek(SEL_COUNT, v); chk("R7 up wrap", v, 0);
    peek(SEL_STATUS, v); chk("R7 carry", v[7], 1);
    pulse(0); peek(SEL_COUNT, v); chk("R7 down wrap", v, 3);
    peek(SEL_STATUS, v); chk("R7 borrow", v[6], 1);

    // R8 index actions
    cmd(OP_WRITE, SEL_MODE0, 32'h10);
    load_cnt(32'h10, 32'h55);
    cmd(OP_CLEAR, SEL_STATUS, 0);
    index(); peek(SEL_COUNT, v); chk("R8 index load", v, 32'h55);
    peek(SEL_STATUS, v); chk("R8 index latch", v[4], 1);
    cmd(OP_WRITE, SEL_MODE0, 32'h20);
    index(); peek(SEL_COUNT, v); chk("R8 index clear", v, 0);
    cmd(OP_WRITE, SEL_MODE0, 32'h30);
    load_cnt(32'h42, 32'h55);
    index(); peek(SEL_SNAP, v); chk("R8 index snapshot", v, 32'h42);
    peek(SEL_COUNT, v); chk("R8 snapshot keeps count", v, 32'h42);
    cmd(OP_WRITE, SEL_MODE0, 32'h00);
    cmd(OP_CLEAR, SEL_STATUS, 0);
    index(); peek(SEL_COUNT, v); chk("R8 no action", v, 32'h42);
    peek(SEL_STATUS, v); chk("R8 latch without action", v[4], 1);

    // R9 compare, R10 clear
    load_cnt(4, 5);
    cmd(OP_CLEAR, SEL_STATUS, 0);
    pulse(1); peek(SEL_STATUS, v); chk("R9 compare on reach", v[5], 1);
    chk("R9 compare dflag", dflag_no, 0);
    cmd(OP_CLEAR, SEL_STATUS, 0);
    peek(SEL_STATUS, v); chk("R10 cleared status", v, 32'h08);
    chk("R10 lflag released", lflag_no, 1);

    // R11 masking
    cmd(OP_WRITE, SEL_MODE1, 32'h03);
    load_cnt(32'hFF, 32'h10);
    cmd(OP_CLEAR, SEL_STATUS, 0);
    pulse(1); peek(SEL_STATUS, v); chk("R11 masked latch", v[7], 1);
    chk("R11 masked lflag", lflag_no, 1); chk("R11 masked dflag", dflag_no, 1);
    cmd(OP_WRITE, SEL_MODE1, 32'h83);
    load_cnt(32'h0F, 32'h10);
    cmd(OP_CLEAR, SEL_STATUS, 0);
    pulse(1); chk("R11 compare not enabled", lflag_no, 1);
    load_cnt(32'hFF, 32'h10);
    pulse(1); chk("R11 carry enabled", lflag_no, 0);
    chk("R11 carry dflag", dflag_no, 0);

    // R12 commands
    cmd(OP_WRITE, SEL_MODE1, 32'hF3);
    load_cnt(32'h21, 32'h10);
    cmd(OP_READ, SEL_COUNT, 0);
    peek(SEL_SNAP, v); chk("R12 read snapshots", v, 32'h21);
    pulse(1); peek(SEL_SNAP, v); chk("R12 snapshot holds", v, 32'h21);
    cmd(OP_XFER, SEL_SNAP, 0);
    peek(SEL_SNAP, v); chk("R12 snapshot transfer", v, 32'h22);
    cmd(OP_CLEAR, SEL_COUNT, 0);
    peek(SEL_COUNT, v); chk("R12 counter clear", v, 0);
    cmd(OP_WRITE, SEL_MODE0, 32'hFF);
    peek(SEL_MODE0, v); chk("R12 mode0 spare bits", v, 32'h3C);
    cmd(OP_CLEAR, SEL_MODE0, 0);
    peek(SEL_MODE0, v); chk("R12 mode0 clear", v, 0);
    peek(SEL_STATUS, v);
    cmd(OP_WRITE, SEL_STATUS, 32'hFF);
    peek(SEL_STATUS, v2); chk("R12 status write ignored", v2, v);

    // R13 command beats strobe
    load_cnt(32'h30, 32'h40);
    cnt_pulse_i = 1; cnt_up_i = 1;
    cmd(OP_XFER, SEL_COUNT, 0);
    cnt_pulse_i = 0;
    peek(SEL_COUNT, v); chk("R13 load wins", v, 32'h40);
    cnt_pulse_i = 1; cnt_up_i = 0;
    cmd(OP_CLEAR, SEL_COUNT, 0);
    cnt_pulse_i = 0;
    peek(SEL_COUNT, v); chk("R13 clear wins", v, 0);

    // random runs in every count mode (R2 R5 R6 R7 R9 R11)
    for (int m = 0; m < 4; m++) begin
      for (int run = 0; run < 10; run++) begin
        logic [1:0]  w  = 2'($urandom % 4);
        logic [31:0] mk = wmask(w);
        logic [31:0] d  = ($urandom % 2) ? ($urandom & mk) : ($urandom % 8);
        logic [31:0] c;
        logic        halt = 0;
        if (m >= 2) c = (d == 0) ? 0 : ($urandom % (d + 1));
        else c = ($urandom % 2) ? (mk - ($urandom % 3)) : ($urandom % 3);
        cmd(OP_WRITE, SEL_MODE1, {24'd0, 6'b111100, w});
        cmd(OP_WRITE, SEL_MODE0, 32'(m) << 2);
        load_cnt(c, d);
        for (int s = 0; s < 30; s++) begin
          logic p  = ($urandom % 4) != 0;
          logic en = ($urandom % 8) != 0;
          logic up = 1'($urandom);
          logic go = p && en && !halt;
          logic [33:0] r = ref_next(c, up, 2'(m), d, mk);
          logic hit = go && (r[33] || r[32] || r[31:0] == d);
          cnt_en_i = en;
          pulse(up);
          if (go) begin
            c = r[31:0];
            if (m == 1 && (r[33] || r[32])) halt = 1;
          end
          peek(SEL_COUNT, v); chk("R2 R6 R7 random count", v, c);
          chk("R11 random dflag", dflag_no, !hit);
        end
      end
    end
    cnt_en_i = 1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule